// File: doc/BRIEF.md
# PTP Packet Timestamp Capture Latch

This block takes a snapshot of the free-running system time whenever a qualifying precision-time packet passes the receive or the transmit side of a network port. Each side owns one single-entry latch. A capture stores the full time value and raises that side's valid flag. The latch then stays locked: later packets do not overwrite it until software reads the upper word of the stored stamp. That read releases the latch and drops the valid flag. Software reads the lower word first and the upper word last, so the pair it reads always belongs to one packet.

On receive, the packet parser delivers one metadata strobe per packet. The strobe carries an is-UDP flag, the ethertype, the UDP destination port, the PTP version and the message type. The message type is the low nibble of the first PTP header byte. A one-bit mode input selects the receive qualification:
- Version-1 mode takes only UDP event-port packets of one chosen message type.
- Version-2 event mode takes every version-2 event message. That includes path-delay requests and responses, carried either over UDP or as layer-2 frames with the PTP ethertype when the layer-2 filter is enabled.

On transmit, the start-of-frame strobe of a packet that is marked for stamping triggers the capture. The transmit latch is independent of the receive latch.

The metadata and start-of-frame strobes are single-cycle valid pulses with no ready. The block accepts a strobe in every cycle and never applies back-pressure. A strobe that meets a locked latch is dropped, not held.

Top module: `ts_capture_unit`

## Requirements
- R1: After reset, `rx_valid` and `tx_valid` are low and every read address returns zero.
- R2: In version-1 mode (`rx_mode`=0), a strobe is captured if all of the following hold: `rx_meta_is_l4`=1, the UDP port is 319, the version is 1, and the message type equals `v1_msg_type`. The value of `time_in` at that clock edge is stored, and `rx_valid` is high from the next cycle.
- R3: Version-1 mode rejects each of these: another message type, another port, version 2, and layer-2 frames.
- R4: In version-2 event mode (`rx_mode`=1), a version-2 packet with message type 0 to 3 is captured if either of these holds:
  - it arrives over UDP port 319;
  - it is a layer-2 frame (`rx_meta_is_l4`=0) with ethertype 0x88F7 and `l2_filt_en`=1.
- R5: Version-2 event mode rejects each of these: message types 4 and above, version-1 packets, layer-2 frames while `l2_filt_en`=0, other ethertypes, and other UDP ports.
- R6: While a side's valid flag is high, further qualifying strobes leave the stored stamp and the flag unchanged.
- R7: Read addresses: `rd_addr` 0 is receive low word, 1 is receive high word, 2 is transmit low word, 3 is transmit high word. `rd_data` shows the addressed word in the same cycle. A `rd_en` on address 1 or 3 releases that side, and its valid flag is low from the next cycle. A read of a low word releases nothing.
- R8: A transmit capture happens only when `tx_sof`, `tx_mark` and `tx_en` are all high. It does not change the receive latch.
- R9: While `rx_en` or `tx_en` is low, that side captures nothing.
- R10: A qualifying strobe that arrives in the same cycle as the release read of a locked latch is dropped, and the flag goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive capture enable |
| rx_mode | input | 1 | 0 selects version-1 UDP mode, 1 selects version-2 event mode |
| l2_filt_en | input | 1 | Enables the layer-2 PTP ethertype filter |
| v1_msg_type | input | 4 | Message type to capture in version-1 mode |
| tx_en | input | 1 | Transmit capture enable |
| rx_meta_valid | input | 1 | Receive metadata strobe |
| rx_meta_is_l4 | input | 1 | Packet is UDP (1) or layer-2 (0) |
| rx_meta_ethtype | input | 16 | Ethertype of the frame |
| rx_meta_udp_dport | input | 16 | UDP destination port |
| rx_meta_ver | input | 4 | PTP version |
| rx_meta_msgtype | input | 4 | Low nibble of the first PTP header byte |
| tx_sof | input | 1 | Transmit start-of-frame strobe |
| tx_mark | input | 1 | Transmit packet is marked for stamping |
| time_in | input | 64 | Current system time |
| rd_en | input | 1 | Read strobe (releases the latch on a high-word address) |
| rd_addr | input | 2 | Read word select |
| rd_data | output | 32 | Addressed timestamp word |
| rx_valid | output | 1 | Receive stamp held |
| tx_valid | output | 1 | Transmit stamp held |

## Verification
A capture appears one clock after its strobe edge, so the bench drives each strobe on a falling edge and samples `rx_valid`, `tx_valid` and `rd_data` on the next falling edge. `rd_data` is combinational on `rd_addr`, so the bench samples it a short delay after changing the address within the same low phase. A release read takes effect one edge later, and the bench checks the flag on the falling edge that follows the read. Lock and collision cases use the same one-edge spacing, so each check observes exactly one edge of state change.

// File: rtl/ts_pkg.sv
package ts_pkg;
  typedef enum logic {
    MODE_V1_L4    = 1'b0,
    MODE_V2_EVENT = 1'b1
  } rx_mode_e;

  typedef struct packed {
    logic        is_l4;
    logic [15:0] ethtype;
    logic [15:0] udp_dport;
    logic [3:0]  ver;
    logic [3:0]  msgtype;
  } rx_meta_t;

  localparam int unsigned N_PATHS = 2;
  localparam int unsigned PATH_RX = 0;
  localparam int unsigned PATH_TX = 1;
endpackage

// File: rtl/ts_rx_match.sv
module ts_rx_match
  import ts_pkg::*;
#(
  parameter logic [15:0] EVENT_PORT = 16'd319,
  parameter logic [15:0] PTP_ETYPE  = 16'h88F7
) (
  input  rx_meta_t    meta,
  input  rx_mode_e    mode,
  input  logic        l2_filt_en,
  input  logic [3:0]  v1_type,
  output logic        hit
);
  logic l4_event, l2_event, v1_hit, v2_hit, is_event_msg;

  always_comb begin
    l4_event     = meta.is_l4 && (meta.udp_dport == EVENT_PORT);
    l2_event     = !meta.is_l4 && l2_filt_en && (meta.ethtype == PTP_ETYPE);
    is_event_msg = (meta.msgtype[3:2] == 2'b00);
    v1_hit       = l4_event && (meta.ver == 4'd1) && (meta.msgtype == v1_type);
    v2_hit       = (meta.ver == 4'd2) && is_event_msg && (l4_event || l2_event);
    hit          = (mode == MODE_V1_L4) ? v1_hit : v2_hit;
  end
endmodule

// File: rtl/ts_latch.sv
module ts_latch #(
  parameter int unsigned TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_req,
  input  logic              rel_req,
  input  logic [TIME_W-1:0] time_in,
  output logic              valid,
  output logic [TIME_W-1:0] stamp
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      stamp <= '0;
    end else if (valid) begin
      if (rel_req) valid <= 1'b0;
    end else if (cap_req) begin
      valid <= 1'b1;
      stamp <= time_in;
    end
  end

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && cap_req) |=> (valid && stamp == $past(time_in)));

  assert_lock_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !rel_req) |=> (valid && $stable(stamp)));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && rel_req) |=> !valid);

  assert_collide_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && rel_req && cap_req) |=> (!valid && $stable(stamp)));
endmodule

// File: rtl/ts_capture_unit.sv
module ts_capture_unit
  import ts_pkg::*;
#(
  parameter int unsigned TIME_W     = 64,
  parameter logic [15:0] EVENT_PORT = 16'd319,
  parameter logic [15:0] PTP_ETYPE  = 16'h88F7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              rx_mode,
  input  logic              l2_filt_en,
  input  logic [3:0]        v1_msg_type,
  input  logic              tx_en,
  input  logic              rx_meta_valid,
  input  logic              rx_meta_is_l4,
  input  logic [15:0]       rx_meta_ethtype,
  input  logic [15:0]       rx_meta_udp_dport,
  input  logic [3:0]        rx_meta_ver,
  input  logic [3:0]        rx_meta_msgtype,
  input  logic              tx_sof,
  input  logic              tx_mark,
  input  logic [TIME_W-1:0] time_in,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  output logic [TIME_W/2-1:0] rd_data,
  output logic              rx_valid,
  output logic              tx_valid
);
  localparam int unsigned WORD_W = TIME_W / 2;

  rx_meta_t                        meta;
  logic                            rx_hit;
  logic [N_PATHS-1:0]              cap_req, rel_req, valid_v;
  logic [N_PATHS-1:0][TIME_W-1:0]  stamps;

  assign meta = '{is_l4: rx_meta_is_l4, ethtype: rx_meta_ethtype,
                  udp_dport: rx_meta_udp_dport, ver: rx_meta_ver,
                  msgtype: rx_meta_msgtype};

  ts_rx_match #(.EVENT_PORT(EVENT_PORT), .PTP_ETYPE(PTP_ETYPE)) u_match (
    .meta       (meta),
    .mode       (rx_mode_e'(rx_mode)),
    .l2_filt_en (l2_filt_en),
    .v1_type    (v1_msg_type),
    .hit        (rx_hit)
  );

  assign cap_req[PATH_RX] = rx_meta_valid && rx_en && rx_hit;
  assign cap_req[PATH_TX] = tx_sof && tx_mark && tx_en;

  for (genvar p = 0; p < N_PATHS; p++) begin : g_path
    assign rel_req[p] = rd_en && (rd_addr == {p[0], 1'b1});
    ts_latch #(.TIME_W(TIME_W)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_req (cap_req[p]),
      .rel_req (rel_req[p]),
      .time_in (time_in),
      .valid   (valid_v[p]),
      .stamp   (stamps[p])
    );
  end

  always_comb begin
    rd_data = stamps[rd_addr[1]][rd_addr[0]*WORD_W +: WORD_W];
  end

  assign rx_valid = valid_v[PATH_RX];
  assign tx_valid = valid_v[PATH_TX];

  assert_rx_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(rx_meta_valid && rx_en));

  assert_tx_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(tx_sof && tx_mark && tx_en));

  assert_tx_no_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_meta_valid && !rel_req[PATH_RX]) |=> $stable(rx_valid));
endmodule

// File: tb/sim_ts_capture_unit.sv
module sim_ts_capture_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0, rx_mode = 1'b0, l2_filt_en = 1'b0, tx_en = 1'b0;
  logic [3:0] v1_msg_type = '0;
  logic rx_meta_valid = 1'b0, rx_meta_is_l4 = 1'b0;
  logic [15:0] rx_meta_ethtype = '0, rx_meta_udp_dport = '0;
  logic [3:0] rx_meta_ver = '0, rx_meta_msgtype = '0;
  logic tx_sof = 1'b0, tx_mark = 1'b0, rd_en = 1'b0;
  logic [63:0] time_in = '0;
  logic [1:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic rx_valid, tx_valid;
  int n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  ts_capture_unit u0 (.*);

  typedef struct packed {
    logic exp; logic mode; logic l2en; logic l4;
    logic [15:0] eth; logic [15:0] port;
    logic [3:0] ver; logic [3:0] mt; logic [3:0] sel;
  } vec_t;

  localparam vec_t VEC [14] = '{
    '{1'b1, 1'b0, 1'b0, 1'b1, 16'h0800, 16'd319, 4'd1, 4'd0, 4'd0},
    '{1'b1, 1'b0, 1'b0, 1'b1, 16'h0800, 16'd319, 4'd1, 4'd1, 4'd1},
    '{1'b0, 1'b0, 1'b0, 1'b1, 16'h0800, 16'd319, 4'd1, 4'd1, 4'd0},
    '{1'b0, 1'b0, 1'b0, 1'b1, 16'h0800, 16'd320, 4'd1, 4'd0, 4'd0},
    '{1'b0, 1'b0, 1'b0, 1'b1, 16'h0800, 16'd319, 4'd2, 4'd0, 4'd0},
    '{1'b0, 1'b0, 1'b1, 1'b0, 16'h88F7, 16'd0,   4'd1, 4'd0, 4'd0},
    '{1'b1, 1'b1, 1'b0, 1'b1, 16'h0800, 16'd319, 4'd2, 4'd0, 4'd0},
    '{1'b1, 1'b1, 1'b0, 1'b1, 16'h0800, 16'd319, 4'd2, 4'd3, 4'd0},
    '{1'b1, 1'b1, 1'b1, 1'b0, 16'h88F7, 16'd0,   4'd2, 4'd2, 4'd0},
    '{1'b0, 1'b1, 1'b0, 1'b0, 16'h88F7, 16'd0,   4'd2, 4'd0, 4'd0},
    '{1'b0, 1'b1, 1'b1, 1'b0, 16'h0800, 16'd0,   4'd2, 4'd0, 4'd0},
    '{1'b0, 1'b1, 1'b0, 1'b1, 16'h0800, 16'd319, 4'd2, 4'd8, 4'd0},
    '{1'b0, 1'b1, 1'b0, 1'b1, 16'h0800, 16'd319, 4'd1, 4'd0, 4'd0},
    '{1'b0, 1'b1, 1'b0, 1'b1, 16'h0800, 16'd320, 4'd2, 4'd0, 4'd0}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic release_side(input logic [1:0] a);
    @(negedge clk);
    rd_addr = a;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic send_rx(input vec_t v, input logic [63:0] t);
    @(negedge clk);
    rx_mode = v.mode; l2_filt_en = v.l2en; v1_msg_type = v.sel;
    rx_meta_is_l4 = v.l4; rx_meta_ethtype = v.eth; rx_meta_udp_dport = v.port;
    rx_meta_ver = v.ver; rx_meta_msgtype = v.mt;
    time_in = t; rx_meta_valid = 1'b1;
    @(negedge clk);
    rx_meta_valid = 1'b0;
  endtask

  task automatic send_tx(input logic mark, input logic [63:0] t);
    @(negedge clk);
    tx_sof = 1'b1; tx_mark = mark; time_in = t;
    @(negedge clk);
    tx_sof = 1'b0; tx_mark = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] t;
    vec_t v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 tx_valid", tx_valid, 0);
    for (int a = 0; a < 4; a++) begin
      peek(a[1:0], d);
      chk("R1 rd_data", d, 0);
    end

    // R2..R5 qualification table
    rx_en = 1'b1;
    for (int i = 0; i < 14; i++) begin
      t = 64'hA5A5_0000_0000_0000 + 64'(i) * 64'h1_0000_0123;
      send_rx(VEC[i], t);
      chk(VEC[i].exp ? "R2/R4 capture flag" : "R3/R5 reject flag", rx_valid, VEC[i].exp);
      if (VEC[i].exp) begin
        peek(2'd0, d); chk("R2/R4 low word", d, t[31:0]);
        peek(2'd1, d); chk("R2/R4 high word", d, t[63:32]);
        release_side(2'd1);
        chk("R7 released", rx_valid, 0);
      end
    end

    // R6 lock and R7 low-read keeps lock
    v = VEC[6];
    send_rx(v, 64'h1111_2222_3333_4444);
    send_rx(v, 64'h9999_8888_7777_6666);
    chk("R6 still valid", rx_valid, 1);
    peek(2'd0, d); chk("R6 low kept", d, 32'h3333_4444);
    peek(2'd1, d); chk("R6 high kept", d, 32'h1111_2222);
    release_side(2'd0);
    chk("R7 low read no release", rx_valid, 1);

    // R10 capture colliding with release read
    @(negedge clk);
    rd_addr = 2'd1; rd_en = 1'b1;
    time_in = 64'h5555_5555_5555_5555; rx_meta_valid = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; rx_meta_valid = 1'b0;
    chk("R10 dropped", rx_valid, 0);
    peek(2'd0, d); chk("R10 stamp kept", d, 32'h3333_4444);

    // R9 rx disabled
    rx_en = 1'b0;
    send_rx(v, 64'h0123_4567_89AB_CDEF);
    chk("R9 rx disabled", rx_valid, 0);

    // R8 / R9 transmit path
    send_tx(1'b1, 64'hDEAD_BEEF_0000_0001);
    chk("R9 tx disabled", tx_valid, 0);
    tx_en = 1'b1;
    send_tx(1'b0, 64'hDEAD_BEEF_0000_0002);
    chk("R8 unmarked", tx_valid, 0);
    send_tx(1'b1, 64'hCAFE_F00D_1234_5678);
    chk("R8 tx captured", tx_valid, 1);
    chk("R8 rx untouched", rx_valid, 0);
    peek(2'd2, d); chk("R8 tx low", d, 32'h1234_5678);
    peek(2'd3, d); chk("R8 tx high", d, 32'hCAFE_F00D);
    send_tx(1'b1, 64'h0);
    peek(2'd2, d); chk("R6 tx lock", d, 32'h1234_5678);
    release_side(2'd1);
    chk("R7 rx read leaves tx", tx_valid, 1);
    release_side(2'd3);
    chk("R7 tx released", tx_valid, 0);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule